// File: doc/BRIEF.md
# Add-Immediate-Shifted Execute Unit

This unit carries out one register-immediate instruction: it adds a signed 16-bit constant, placed in the upper half of a 32-bit word, to a base register. It decodes a 32-bit instruction word and reads the base operand from its own 32-entry, 64-bit register file. It forms the 64-bit sum, writes the sum back into the register file and steps the program counter by 4.

A zero in the base-register field selects the constant zero, not register 0. With a zero base, the instruction loads the upper half of a 32-bit constant. A mode input narrows the result to 32 bits, zero-extended, for code that runs with a 32-bit data model. When a valid strobe arrives with any other opcode, the unit raises an illegal-opcode flag for that cycle. It then writes nothing and holds the program counter.

Top module: `ais_exec`

## Requirements
- R1: When `instrValid` is high and `instrWord[31:26]` equals 15, `wrEn` is high and `illegalOp` is low in that cycle, and the register file is written at the next rising clock edge.
- R2: The destination index is `instrWord[25:21]` and appears on `wrAddr`. The base index is `instrWord[20:16]`. The immediate is `instrWord[15:0]`.
- R3: A base index of 0 makes the base operand zero, whatever register 0 holds.
- R4: The immediate is sign-extended to 64 bits and then shifted left by 16. An immediate of 0x8000 with a zero base gives 0xFFFFFFFF80000000.
- R5: The sum is a 64-bit modular add. It wraps with no flag, for example 0xFFFFFFFFFFFF0000 + 0x10000 = 0.
- R6: When `mode32` is high, `wrData` carries the low 32 bits of the sum and bits 63:32 are zero.
- R7: `pcOut` increases by 4 after every clock edge that completes a legal instruction.
- R8: While `instrValid` is low, `wrEn` is low, no register changes and `pcOut` holds.
- R9: When `instrValid` is high and the opcode is not 15, `illegalOp` is high for that cycle. `wrEn` stays low, the target register keeps its value and `pcOut` holds.
- R10: A written value is the base operand of an instruction issued in the very next cycle.
- R11: Reset (`rstN` low) sets `pcOut` to the `RESET_PC` parameter (default 0) and clears every register to zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction present this cycle |
| instrWord | input | 32 | Instruction word |
| mode32 | input | 1 | Narrow the result to 32 bits, zero-extended |
| wrEn | output | 1 | Register write happens at the coming edge |
| wrAddr | output | 5 | Destination register index |
| wrData | output | 64 | Value being written |
| illegalOp | output | 1 | Valid instruction with an unknown opcode |
| pcOut | output | 64 | Program counter |

## Verification
The checker tests the following on every cycle:
- opcode decode and the write and illegal strobes (R1, R9);
- destination routing (R2);
- zero-base arithmetic with sign extension (R3, R4);
- the cleared upper word in 32-bit mode (R6);
- the program-counter step and hold (R7, R8, R9).

Only the bench's scenarios can show the register-file contents:
- a non-zero register 0 being ignored as a base;
- a 64-bit wrap;
- a value written in one cycle being used in the next;
- an illegal instruction or an idle cycle leaving the target register untouched.

The bench makes these contents visible by reading the registers back through later instructions.

// File: rtl/ais_pkg.sv
`timescale 1ns/1ps
package ais_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 16;
  localparam logic [OPC_W-1:0] OPC_ADDSH = 6'd15;

  typedef struct packed {
    logic regWrite;
    logic pcStep;
    logic illegal;
  } aisStrobe_t;
endpackage

// File: rtl/ais_ctrl.sv
`timescale 1ns/1ps
module ais_ctrl
  import ais_pkg::*;
(
  input  logic              instrValid,
  input  logic [OPC_W-1:0]  opcode,
  output aisStrobe_t        strobe
);
  logic opcHit;

  always_comb begin
    opcHit          = (opcode == OPC_ADDSH);
    strobe.regWrite = instrValid && opcHit;
    strobe.pcStep   = instrValid && opcHit;
    strobe.illegal  = instrValid && !opcHit;
  end
endmodule

// File: rtl/ais_datapath.sv
`timescale 1ns/1ps
module ais_datapath
  import ais_pkg::*;
#(
  parameter int XLEN             = 64,
  parameter int NREG             = 32,
  parameter int SHIFT            = 16,
  parameter int PC_STEP          = 4,
  parameter logic [63:0] RESET_PC = 64'h0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  aisStrobe_t              strobe,
  input  logic [IDX_W-1:0]        rtIdx,
  input  logic [IDX_W-1:0]        raIdx,
  input  logic [IMM_W-1:0]        imm,
  input  logic                    mode32,
  output logic                    wrEn,
  output logic [IDX_W-1:0]        wrAddr,
  output logic [XLEN-1:0]         wrData,
  output logic [XLEN-1:0]         pcOut
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] regFile [NREG];
  logic [XLEN-1:0] baseVal;
  logic [XLEN-1:0] immWide;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] pcReg;

  always_comb begin
    baseVal = (raIdx == '0) ? '0 : regFile[raIdx];
    immWide = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << SHIFT;
    sum     = baseVal + immWide;
    wrData  = mode32 ? {{(XLEN-HALF){1'b0}}, sum[HALF-1:0]} : sum;
    wrEn    = strobe.regWrite;
    wrAddr  = rtIdx;
    pcOut   = pcReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (strobe.regWrite) begin
      regFile[rtIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pcReg <= RESET_PC[XLEN-1:0];
    else if (strobe.pcStep) pcReg <= pcReg + XLEN'(PC_STEP);
  end
endmodule

// File: rtl/ais_exec.sv
`timescale 1ns/1ps
module ais_exec
  import ais_pkg::*;
#(
  parameter int XLEN             = 64,
  parameter logic [63:0] RESET_PC = 64'h0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic                mode32,
  output logic                wrEn,
  output logic [IDX_W-1:0]    wrAddr,
  output logic [XLEN-1:0]     wrData,
  output logic                illegalOp,
  output logic [XLEN-1:0]     pcOut
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RT_LSB  = OPC_LSB - IDX_W;
  localparam int RA_LSB  = RT_LSB - IDX_W;

  aisStrobe_t strobe;

  ais_ctrl u_ctrl (
    .instrValid (instrValid),
    .opcode     (instrWord[INSTR_W-1 -: OPC_W]),
    .strobe     (strobe)
  );

  ais_datapath #(
    .XLEN     (XLEN),
    .NREG     (1 << IDX_W),
    .SHIFT    (16),
    .PC_STEP  (4),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rtIdx  (instrWord[RT_LSB +: IDX_W]),
    .raIdx  (instrWord[RA_LSB +: IDX_W]),
    .imm    (instrWord[IMM_W-1:0]),
    .mode32 (mode32),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .pcOut  (pcOut)
  );

  assign illegalOp = strobe.illegal;
endmodule

// File: rtl/ais_exec_chk.sv
`timescale 1ns/1ps
module ais_exec_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic [31:0]     instrWord,
  input logic            mode32,
  input logic            wrEn,
  input logic [4:0]      wrAddr,
  input logic [XLEN-1:0] wrData,
  input logic            illegalOp,
  input logic [XLEN-1:0] pcOut
);
  logic opOk;
  assign opOk = (instrWord[31:26] == 6'd15);

  a_r1_legal_writes: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opOk) |-> (wrEn && !illegalOp));

  a_r2_dest_route: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr == instrWord[25:21]));

  a_r4_zero_base_sext: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mode32 && instrWord[20:16] == 5'd0) |->
      (wrData == {{(XLEN-32){instrWord[15]}}, instrWord[15:0], 16'h0000}));

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && mode32) |-> (wrData[XLEN-1:32] == '0));

  a_r7_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opOk) |=> (pcOut == $past(pcOut) + XLEN'(4)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !wrEn);

  a_r8_idle_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(pcOut));

  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !opOk) |-> (illegalOp && !wrEn));

  a_r9_illegal_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> $stable(pcOut));
endmodule

bind ais_exec ais_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .mode32     (mode32),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .illegalOp  (illegalOp),
  .pcOut      (pcOut)
);

// File: tb/ais_exec_bench.sv
`timescale 1ns/1ps
module ais_exec_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        mode32 = 1'b0;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic        illegalOp;
  logic [63:0] pcOut;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  logic [63:0] mReg [32];
  logic [63:0] mPc;

  always #10 clk = ~clk;

  ais_exec u_ais_exec (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .mode32(mode32), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .illegalOp(illegalOp), .pcOut(pcOut)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] ra, input logic [15:0] im);
    return {op, rt, ra, im};
  endfunction

  function automatic logic [63:0] expSum(input logic [31:0] w, input logic m32);
    logic [63:0] b, s;
    b = (w[20:16] == 5'd0) ? 64'h0 : mReg[w[20:16]];
    s = b + ({{48{w[15]}}, w[15:0]} << 16);
    return m32 ? {32'h0, s[31:0]} : s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic m32, input string req);
    logic [63:0] e;
    logic legal;
    @(negedge clk);
    instrWord = w; mode32 = m32; instrValid = 1'b1;
    #1;
    legal = (w[31:26] == 6'd15);
    e = expSum(w, m32);
    chk(wrEn == legal, {req, " R1 wrEn"}, 64'(wrEn), 64'(legal));
    chk(illegalOp == !legal, {req, " R9 illegalOp"}, 64'(illegalOp), 64'(!legal));
    if (legal) begin
      chk(wrData == e, {req, " wrData"}, wrData, e);
      chk(wrAddr == w[25:21], {req, " R2 wrAddr"}, 64'(wrAddr), 64'(w[25:21]));
    end
    @(posedge clk);
    if (legal) begin
      mReg[w[25:21]] = e;
      mPc = mPc + 64'd4;
    end
    #1;
    chk(pcOut == mPc, {req, " R7 pcOut"}, pcOut, mPc);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instrValid = 1'b0;
      instrWord = $urandom;
      #1;
      chk(!wrEn, "R8 wrEn idle", 64'(wrEn), 64'h0);
      @(posedge clk); #1;
      chk(pcOut == mPc, "R8 pc idle", pcOut, mPc);
    end
  endtask

  initial begin
    #2000000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    mPc = 64'h0;
    repeat (3) @(posedge clk);
    #1;
    chk(pcOut == 64'h0, "R11 reset pc", pcOut, 64'h0);
    chk(!wrEn, "R11 reset wrEn", 64'(wrEn), 64'h0);
    @(negedge clk); rstN = 1'b1;

    // R11: registers read back as zero after reset
    issue(enc(6'd15, 5'd1, 5'd7, 16'h0), 1'b0, "R11 r7 zero");
    issue(enc(6'd15, 5'd1, 5'd31, 16'h0), 1'b0, "R11 r31 zero");
    // R4: sign extension then shift
    issue(enc(6'd15, 5'd2, 5'd0, 16'h8000), 1'b0, "R4 load 0x8000");
    chk(mReg[2] == 64'hFFFFFFFF80000000, "R4 model", mReg[2], 64'hFFFFFFFF80000000);
    issue(enc(6'd15, 5'd3, 5'd2, 16'h0), 1'b0, "R4 readback");
    // R3: r0 non-zero but base 0 means zero
    issue(enc(6'd15, 5'd0, 5'd0, 16'h1234), 1'b0, "R3 set r0");
    issue(enc(6'd15, 5'd5, 5'd0, 16'h0001), 1'b0, "R3 zero base");
    chk(mReg[5] == 64'h10000, "R3 model", mReg[5], 64'h10000);
    // R5: wrap to zero
    issue(enc(6'd15, 5'd4, 5'd0, 16'hFFFF), 1'b0, "R5 load -1");
    issue(enc(6'd15, 5'd4, 5'd4, 16'h0001), 1'b0, "R5 wrap");
    chk(mReg[4] == 64'h0, "R5 model", mReg[4], 64'h0);
    issue(enc(6'd15, 5'd6, 5'd4, 16'h0), 1'b0, "R5 readback zero");
    // R6: 32-bit mode
    issue(enc(6'd15, 5'd8, 5'd0, 16'h8000), 1'b1, "R6 narrow");
    chk(mReg[8] == 64'h80000000, "R6 model", mReg[8], 64'h80000000);
    issue(enc(6'd15, 5'd9, 5'd8, 16'h0), 1'b0, "R6 readback");
    // R10: back-to-back chain
    issue(enc(6'd15, 5'd10, 5'd0, 16'h7FFF), 1'b0, "R10 first");
    issue(enc(6'd15, 5'd10, 5'd10, 16'h7FFF), 1'b0, "R10 chained");
    issue(enc(6'd15, 5'd11, 5'd10, 16'h0), 1'b0, "R10 readback");
    // R9: illegal opcode leaves target and pc alone
    issue(enc(6'd14, 5'd10, 5'd0, 16'h1111), 1'b0, "R9 illegal");
    issue(enc(6'd15, 5'd12, 5'd10, 16'h0), 1'b0, "R9 target intact");
    // R8: idle cycles
    idle(4);
    issue(enc(6'd15, 5'd12, 5'd11, 16'h0), 1'b0, "R8 regs intact");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] op;
      op = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'd15;
      if (($urandom_range(0, 7)) == 0) idle(1);
      issue(enc(op, 5'($urandom), 5'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                16'($urandom)), 1'($urandom), "R1 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule